// File: doc/BRIEF.md
# Synchronous 12-hour minute clock

This block keeps the time of day on a 12-hour dial at a resolution of one minute. It is a three-digit counter: minute units run 0 to 9, minute tens run 0 to 5, and the hour is held in binary as 0 to 11. Every register is clocked by the same input, which runs at one pulse per minute. No counter stage ever drives the clock of another stage.

Each digit is built from the same three parts. A register holds the digit. An incrementer adds its carry-in to the digit, so a carry-in of 0 leaves the value unchanged and the carry-in works as an enable. A two-way mux then passes either the incremented value or zero. Rollover works through equality detectors. A detector gates the carry-in of the next digit, and the same detector, combined with the digit's own carry-in, selects the zero input of the mux.

The stored hour 0..11 is displayed as 1..12. The block drives one-hot lines for the minute units, the minute tens and the hour-units digit, plus a single tens-of-hours indicator. These outputs are meant to drive numeric display tubes or lamps directly.

Top module: `sync_minute_clock`

## Requirements
- R1: While `rst` is high at a clock edge, all three digits return to zero at that edge. The clock then displays 1:00: `min_units_oh` = bit 0 only, `min_tens_oh` = bit 0 only, `hour_units_oh` = bit 1 only, and `hour_tens_on` = 0.
- R2: Minute units advance by one on every clock edge out of reset, and go from 9 to 0.
- R3: Minute tens advance by one only on an edge where minute units are 9, and otherwise hold their value.
- R4: Minute tens at 5 go to 0 on the edge where minute units are also 9.
- R5: The hour count advances only on an edge where the minutes read 59, and otherwise holds its value.
- R6: The displayed time 12:59 (stored hour 11) becomes 1:00 (stored hour 0) on the next edge.
- R7: `hour_tens_on` is 1 exactly when the displayed hour is 10, 11 or 12, that is for stored values 9, 10 and 11.
- R8: `hour_units_oh` has a single line set, at index (stored hour + 1) mod 10.
- R9: Each one-hot output has exactly one line set, and bit i of that output means the digit value is i.
- R10: Reset is synchronous. Raising it in the middle of a count has no effect until the next edge, and that edge displays 1:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared one-pulse-per-minute clock |
| rst | input | 1 | Synchronous reset, active high |
| min_units_oh | output | 10 | Minute units, one-hot, bit i = digit i |
| min_tens_oh | output | 6 | Minute tens, one-hot, bit i = digit i |
| hour_units_oh | output | 10 | Displayed hour units, one-hot, bit i = digit i |
| hour_tens_on | output | 1 | Displayed hour is 10 to 12 |

## Verification
Every output is a combinational decode of the three registers, so each result is due one edge after the stimulus: the reset or clock edge that changes the digits. The bench updates its behavioural time model at the same edge it drives. It then compares all four outputs at the following falling edge, when the registers and decoders have settled. The run covers more than a full 12-hour cycle so that every rollover combination appears, and it includes a reset raised in the middle of a count.

// File: rtl/clk12_pkg.sv
package clk12_pkg;
   localparam int DIGIT_W   = 4;
   localparam int MU_LAST   = 9;
   localparam int MT_LAST   = 5;
   localparam int HR_LAST   = 11;
   localparam int DEC_LINES = 10;
   typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/count_digit.sv
module count_digit #(
   parameter int W      = 4,
   parameter int LAST   = 9,
   parameter bit SPARSE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         carry_in,
   output logic [W-1:0] q,
   output logic         at_last
);
   localparam logic [W-1:0] LAST_V = W'(LAST);

   generate
      if (LAST < 1 || LAST >= (1 << W)) begin : g_bad
         $error("count_digit: LAST does not fit in W bits");
      end
      if (SPARSE) begin : g_sparse
         // only the bits set in LAST are examined; values above LAST never occur
         assign at_last = ((q & LAST_V) == LAST_V);
      end else begin : g_full
         assign at_last = (q == LAST_V);
      end
   endgenerate

   logic [W-1:0] inc_v;
   logic [W-1:0] d;
   logic         wrap;

   assign inc_v = q + {{(W-1){1'b0}}, carry_in};
   assign wrap  = carry_in & at_last;
   assign d     = wrap ? '0 : inc_v;

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   // R3 R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !carry_in |=> $stable(q));
   // R4 R6
   wrap_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (carry_in && q == LAST_V) |=> (q == '0));
   // R2
   range_chk: assert property (@(posedge clk) disable iff (rst)
      q <= LAST_V);
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
   parameter int W = 4,
   parameter int N = 10
) (
   input  logic [W-1:0] val,
   output logic [N-1:0] lines
);
   generate
      if (N > (1 << W)) begin : g_bad
         $error("onehot_dec: N exceeds 2**W");
      end
      for (genvar i = 0; i < N; i++) begin : g_line
         assign lines[i] = (val == W'(i));
      end
   endgenerate
endmodule

// File: rtl/hour_display.sv
module hour_display #(
   parameter int W      = 4,
   parameter bit SPARSE = 1'b1
) (
   input  logic [W-1:0] hr,
   output logic         tens_on,
   output logic [W-1:0] units
);
   generate
      if (W != 4) begin : g_bad
         $error("hour_display: hour register must be 4 bits");
      end
      if (SPARSE) begin : g_sparse
         assign tens_on = hr[3] & (hr[1] | hr[0]);
      end else begin : g_full
         assign tens_on = (hr >= W'(9));
      end
   endgenerate

   logic [W-1:0] shown;
   assign shown = hr + W'(1);
   assign units = tens_on ? (shown - W'(10)) : shown;
endmodule

// File: rtl/sync_minute_clock.sv
module sync_minute_clock
   import clk12_pkg::*;
#(
   parameter bit SPARSE_DETECT = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   output logic [9:0]  min_units_oh,
   output logic [5:0]  min_tens_oh,
   output logic [9:0]  hour_units_oh,
   output logic        hour_tens_on
);
   digit_t mu_q, mt_q, hr_q, hr_units;
   logic   mu_last, mt_last, hr_last;
   logic   mt_en, hr_en;

   assign mt_en = mu_last;
   assign hr_en = mu_last & mt_last;

   count_digit #(.W(DIGIT_W), .LAST(MU_LAST), .SPARSE(SPARSE_DETECT)) u_mu (
      .clk(clk), .rst(rst), .carry_in(1'b1), .q(mu_q), .at_last(mu_last));
   count_digit #(.W(DIGIT_W), .LAST(MT_LAST), .SPARSE(SPARSE_DETECT)) u_mt (
      .clk(clk), .rst(rst), .carry_in(mt_en), .q(mt_q), .at_last(mt_last));
   count_digit #(.W(DIGIT_W), .LAST(HR_LAST), .SPARSE(SPARSE_DETECT)) u_hr (
      .clk(clk), .rst(rst), .carry_in(hr_en), .q(hr_q), .at_last(hr_last));

   hour_display #(.W(DIGIT_W), .SPARSE(SPARSE_DETECT)) u_hdisp (
      .hr(hr_q), .tens_on(hour_tens_on), .units(hr_units));

   onehot_dec #(.W(DIGIT_W), .N(DEC_LINES))   u_dec_mu (.val(mu_q),     .lines(min_units_oh));
   onehot_dec #(.W(DIGIT_W), .N(MT_LAST + 1)) u_dec_mt (.val(mt_q),     .lines(min_tens_oh));
   onehot_dec #(.W(DIGIT_W), .N(DEC_LINES))   u_dec_hu (.val(hr_units), .lines(hour_units_oh));

   logic unused_hr_last;
   assign unused_hr_last = hr_last;

   // R1 R10
   reset_face_chk: assert property (@(posedge clk)
      rst |=> (min_units_oh == 10'b1 && min_tens_oh == 6'b1 &&
               hour_units_oh == 10'b10 && !hour_tens_on));
   // R9
   onehot_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(min_units_oh) == 1 && $countones(min_tens_oh) == 1 &&
       $countones(hour_units_oh) == 1));
   // R6
   noon_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (min_units_oh[9] && min_tens_oh[5] && hour_tens_on && hour_units_oh[2])
      |=> (!hour_tens_on && hour_units_oh[1]));
   // R7
   tens_digit_chk: assert property (@(posedge clk) disable iff (rst)
      hour_tens_on |-> (hour_units_oh[0] || hour_units_oh[1] || hour_units_oh[2]));
endmodule

// File: tb/sync_minute_clock_tb.sv
module sync_minute_clock_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [9:0] min_units_oh;
   logic [5:0] min_tens_oh;
   logic [9:0] hour_units_oh;
   logic       hour_tens_on;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int m_u = 0, m_t = 0, h = 0;

   always #2 clk = ~clk;

   sync_minute_clock u_dut (
      .clk(clk), .rst(rst),
      .min_units_oh(min_units_oh), .min_tens_oh(min_tens_oh),
      .hour_units_oh(hour_units_oh), .hour_tens_on(hour_tens_on));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_step(input bit r);
      bool_update: begin
         if (r) begin
            m_u = 0; m_t = 0; h = 0;
         end else begin
            bit u9 = (m_u == 9);
            bit t5 = (m_t == 5);
            if (u9 && t5) h = (h == 11) ? 0 : h + 1;
            if (u9) m_t = t5 ? 0 : m_t + 1;
            m_u = u9 ? 0 : m_u + 1;
         end
      end
   endtask

   task automatic compare(input string tag);
      int shown = h + 1;
      chk({tag, " R2 R9 minute units"}, int'(min_units_oh), 1 << m_u);
      chk({tag, " R3 R4 minute tens"},  int'(min_tens_oh),  1 << m_t);
      chk({tag, " R5 R6 R8 hour units"}, int'(hour_units_oh), 1 << (shown % 10));
      chk({tag, " R7 hour tens"},        int'(hour_tens_on), (shown >= 10) ? 1 : 0);
   endtask

   task automatic step(input bit r, input string tag);
      rst = r;
      @(posedge clk);
      model_step(r);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      @(negedge clk);
      step(1'b1, "R1 reset");
      chk("R1 display 1:00 hour units", int'(hour_units_oh), 10'b10);
      for (int i = 0; i < 37; i++) step(1'b0, "count");
      // R10: reset mid-count, effective at the next edge only
      rst = 1'b1;
      #1;
      chk("R10 before edge minute units", int'(min_units_oh), 1 << m_u);
      @(posedge clk);
      model_step(1'b1);
      @(negedge clk);
      compare("R10 mid reset");
      chk("R10 minute units zero", int'(min_units_oh), 1);
      // over a full 12-hour cycle to hit every rollover, including 12:59
      for (int i = 0; i < 760; i++) step(1'b0, "run");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule